// File: doc/BRIEF.md
# Programmable Output Sync Generator

This block produces the timing skeleton for a display output after scan-rate conversion. It runs a pixel counter and a line counter and decodes them into horizontal sync, vertical sync, a horizontal active strobe and a vertical active strobe. Both counters are also brought out so that downstream logic can address the picture.

Three register fields are scaled by fixed factors. The line length is given in units of four pixels, the active width in units of sixteen pixels, and the free-running field length in units of two lines. The horizontal offset of the picture and the vertical blank and active windows are given directly, in pixels and lines.

The vertical counter has two modes. In free-running mode it wraps at the programmed field length. In locked mode the field-length field is ignored and the field follows a reference pulse taken from the incoming video. A pulse schedules a restart of the line counter at the next line boundary.

Top module: `scan_sync_gen`

## Requirements
- R1: The pixel counter counts 0 to 4*`line_len`-1 and then returns to 0. The line counter changes only on the clock edge where the pixel counter wraps.
- R2: `hsync` is high exactly while the pixel counter is below the parameter `HSYNC_PIX` (default 8).
- R3: `h_active` is high exactly while `hblank` <= pixel < `hblank` + 16*`act_width`. It is cut off at the end of the line when that sum exceeds the line length. `hblank` = 0 starts the active region on pixel 0.
- R4: With `lock_mode` = 0 (free-running), the line counter wraps to 0 after line 2*`field_len`-1.
- R5: `vsync` is high exactly while the line counter is below the parameter `VSYNC_LINES` (default 2).
- R6: `v_active` is high exactly while `vblank` <= line < `vblank` + `act_lines`. In free-running mode it is also cut off at the field end (line < 2*`field_len`).
- R7: With `lock_mode` = 1, `field_len` has no effect. A clock on which `vref` is high arms a restart, including a clock on the last pixel of a line. At the next wrap of the pixel counter the line counter goes to 0. With no restart armed, the line counter increments at each line end and saturates at its maximum value.
- R8: With `lock_mode` = 0, `vref` has no effect, and a restart armed earlier in locked mode is discarded.
- R9: While `rst_n` is low and on release, both counters are 0, `hsync` and `vsync` are high, and no restart is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_len | input | 10 | Line length in units of 4 pixels |
| act_width | input | 7 | Active width in units of 16 pixels |
| hblank | input | 12 | Blank pixels before the active region |
| field_len | input | 9 | Free-running field length in units of 2 lines |
| vblank | input | 10 | Blank lines before the vertical active region |
| act_lines | input | 10 | Active lines per field |
| lock_mode | input | 1 | 1 = locked to `vref`, 0 = free-running |
| vref | input | 1 | Vertical reference pulse from the input video |
| pix_cnt | output | 12 | Current pixel index within the line |
| line_cnt | output | 10 | Current line index within the field |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| h_active | output | 1 | Horizontal active region |
| v_active | output | 1 | Vertical active region |

## Verification
The bench targets windows programmed past the end of the line or field. A design that did not cut them off would raise an active strobe on pixels or lines that never occur, or carry the strobe into the next line. It also places reference pulses on the last pixel of a line and holds the reference high continuously. A design that sampled the reference one clock late would miss the restart by a full line and let the line counter reach 1. Free-running configurations receive dense reference pulses and a tiny field register is paired with locked mode; a design that mixed the two modes would then wrap lines early or restart on pulses that must be ignored.

// File: rtl/scan_sync_pkg.sv
package scan_sync_pkg;

  typedef enum logic {
    VMODE_FREE = 1'b0,
    VMODE_LOCK = 1'b1
  } vmode_e;

  // Line length register is in units of 4 pixels.
  function automatic int px_per_line(input int reg_val);
    return reg_val * 4;
  endfunction

  // Active width register is in units of 16 pixels.
  function automatic int act_px(input int reg_val);
    return reg_val * 16;
  endfunction

  // Free-running field length register is in units of 2 lines.
  function automatic int lines_per_field(input int reg_val);
    return reg_val * 2;
  endfunction

  // Half-open window test: start <= pos < start + len.
  function automatic logic in_window(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

endpackage

// File: rtl/scan_h_timer.sv
module scan_h_timer #(
  parameter int LL_W      = 10,
  parameter int AW_W      = 7,
  parameter int HSYNC_PIX = 8,
  localparam int PIX_W    = LL_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LL_W-1:0]  line_len,
  input  logic [AW_W-1:0]  act_width,
  input  logic [PIX_W-1:0] hblank,
  output logic [PIX_W-1:0] pix,
  output logic             line_end,
  output logic             hsync,
  output logic             hact
);
  import scan_sync_pkg::*;

  int total_px;
  int active_px;

  always_comb begin
    total_px  = px_per_line(int'(line_len));
    active_px = act_px(int'(act_width));
  end

  assign line_end = int'(pix) >= total_px - 1;

  always_ff @(posedge clk) begin
    if (!rst_n)        pix <= '0;
    else if (line_end) pix <= '0;
    else               pix <= pix + 1'b1;
  end

  assign hsync = int'(pix) < HSYNC_PIX;
  assign hact  = in_window(int'(pix), int'(hblank), active_px) && (int'(pix) < total_px);

  AST_PIX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (pix == '0)); // R1
  AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> (pix == $past(pix) + 1'b1)); // R1
  AST_HSYNC_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix == '0) |-> hsync); // R2
  AST_HACT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    hact |-> (pix >= hblank)); // R3

endmodule

// File: rtl/scan_v_timer.sv
module scan_v_timer #(
  parameter int FL_W        = 9,
  parameter int VSYNC_LINES = 2,
  localparam int LN_W       = FL_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line_end,
  input  logic            locked,
  input  logic            vref,
  input  logic [FL_W-1:0] field_len,
  input  logic [LN_W-1:0] vblank,
  input  logic [LN_W-1:0] act_lines,
  output logic [LN_W-1:0] line,
  output logic            vsync,
  output logic            vact,
  output logic            restart_now,
  output logic            field_end
);
  import scan_sync_pkg::*;

  logic pend;
  int   field_lines;

  always_comb field_lines = lines_per_field(int'(field_len));

  assign restart_now = locked && (pend || vref);
  assign field_end   = !locked && (int'(line) >= field_lines - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line <= '0;
      pend <= 1'b0;
    end else if (line_end) begin
      pend <= 1'b0;
      if (restart_now || field_end) line <= '0;
      else if (line != '1)          line <= line + 1'b1;
    end else begin
      pend <= locked && (pend || vref);
    end
  end

  assign vsync = int'(line) < VSYNC_LINES;
  assign vact  = in_window(int'(line), int'(vblank), int'(act_lines))
                 && (locked || (int'(line) < field_lines));

  AST_LOCK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && restart_now) |=> (line == '0)); // R7
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && field_end) |=> (line == '0)); // R4
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line)); // R1
  AST_FREE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |=> !pend); // R8
  AST_VACT_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    vact |-> (line >= vblank)); // R6

endmodule

// File: rtl/scan_sync_gen.sv
module scan_sync_gen #(
  parameter int LL_W        = 10,
  parameter int AW_W        = 7,
  parameter int FL_W        = 9,
  parameter int HSYNC_PIX   = 8,
  parameter int VSYNC_LINES = 2,
  localparam int PIX_W      = LL_W + 2,
  localparam int LN_W       = FL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LL_W-1:0]  line_len,
  input  logic [AW_W-1:0]  act_width,
  input  logic [PIX_W-1:0] hblank,
  input  logic [FL_W-1:0]  field_len,
  input  logic [LN_W-1:0]  vblank,
  input  logic [LN_W-1:0]  act_lines,
  input  logic             lock_mode,
  input  logic             vref,
  output logic [PIX_W-1:0] pix_cnt,
  output logic [LN_W-1:0]  line_cnt,
  output logic             hsync,
  output logic             vsync,
  output logic             h_active,
  output logic             v_active
);
  import scan_sync_pkg::*;

  logic   line_end;
  logic   restart_now;
  logic   field_end;
  vmode_e vmode;

  assign vmode = vmode_e'(lock_mode);

  scan_h_timer #(
    .LL_W(LL_W), .AW_W(AW_W), .HSYNC_PIX(HSYNC_PIX)
  ) u_h (
    .clk(clk), .rst_n(rst_n),
    .line_len(line_len), .act_width(act_width), .hblank(hblank),
    .pix(pix_cnt), .line_end(line_end), .hsync(hsync), .hact(h_active)
  );

  scan_v_timer #(
    .FL_W(FL_W), .VSYNC_LINES(VSYNC_LINES)
  ) u_v (
    .clk(clk), .rst_n(rst_n),
    .line_end(line_end), .locked(vmode == VMODE_LOCK), .vref(vref),
    .field_len(field_len), .vblank(vblank), .act_lines(act_lines),
    .line(line_cnt), .vsync(vsync), .vact(v_active),
    .restart_now(restart_now), .field_end(field_end)
  );

  AST_NO_DOUBLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart_now && field_end)); // R8
  AST_RESET_SYNC: assert property (@(posedge clk)
    !rst_n |=> (pix_cnt == '0 && line_cnt == '0)); // R9

endmodule

// File: tb/sim_scan_sync_gen.sv
`timescale 1ns/1ps
module sim_scan_sync_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  line_len = 10'd6;
  logic [6:0]  act_width = 7'd1;
  logic [11:0] hblank = 12'd0;
  logic [8:0]  field_len = 9'd5;
  logic [9:0]  vblank = 10'd0;
  logic [9:0]  act_lines = 10'd1;
  logic        lock_mode = 1'b0;
  logic        vref = 1'b0;
  logic [11:0] pix_cnt;
  logic [9:0]  line_cnt;
  logic        hsync, vsync, h_active, v_active;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_sync_gen u0 (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .act_width(act_width),
    .hblank(hblank), .field_len(field_len), .vblank(vblank),
    .act_lines(act_lines), .lock_mode(lock_mode), .vref(vref),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt), .hsync(hsync), .vsync(vsync),
    .h_active(h_active), .v_active(v_active)
  );

  // Bench model state
  int  m_pix, m_line;
  bit  m_arm;

  function automatic bit win(int p, int s, int l);
    return (p >= s) && (p - s < l);
  endfunction

  function automatic bit exp_hact(int p);
    return win(p, int'(hblank), 16 * int'(act_width)) && (p < 4 * int'(line_len));
  endfunction

  function automatic bit exp_vact(int l);
    return win(l, int'(vblank), int'(act_lines)) &&
           (lock_mode || l < 2 * int'(field_len));
  endfunction

  task automatic advance(input bit ref_seen);
    if (m_pix + 1 >= 4 * int'(line_len)) begin
      m_pix = 0;
      if (lock_mode && (m_arm || ref_seen)) m_line = 0;          // R7
      else if (!lock_mode && m_line + 1 >= 2 * int'(field_len)) m_line = 0; // R4
      else if (m_line < 1023) m_line++;
      m_arm = 0;
    end else begin
      m_pix++;
      m_arm = lock_mode && (m_arm || ref_seen);                 // R8 drops it
    end
  endtask

  task automatic compare(input string tag);
    bit bad = 0;
    n_vec++;
    if (int'(pix_cnt) != m_pix) begin
      bad = 1; $display("FAIL R1 %s pix_cnt act=%0d exp=%0d", tag, pix_cnt, m_pix);
    end
    if (int'(line_cnt) != m_line) begin
      bad = 1;
      $display("FAIL %s line_cnt act=%0d exp=%0d", lock_mode ? "R7" : "R4/R8", line_cnt, m_line);
    end
    if (hsync != (m_pix < 8)) begin
      bad = 1; $display("FAIL R2 %s hsync act=%0b exp=%0b", tag, hsync, m_pix < 8);
    end
    if (h_active != exp_hact(m_pix)) begin
      bad = 1; $display("FAIL R3 %s h_active act=%0b exp=%0b", tag, h_active, exp_hact(m_pix));
    end
    if (vsync != (m_line < 2)) begin
      bad = 1; $display("FAIL R5 %s vsync act=%0b exp=%0b", tag, vsync, m_line < 2);
    end
    if (v_active != exp_vact(m_line)) begin
      bad = 1; $display("FAIL R6 %s v_active act=%0b exp=%0b", tag, v_active, exp_vact(m_line));
    end
    if (bad) n_bad++;
  endtask

  // rate: 0 never, 1 always, N about one in N cycles; last_px forces pulses on last pixel
  task automatic run_cfg(input int ll, input int aw, input int hb, input int fl,
                         input int vb, input int vl, input bit lk, input int rate,
                         input bit last_px, input int ncyc, input string tag);
    @(negedge clk);
    rst_n = 1'b0; vref = 1'b0;
    line_len = 10'(ll); act_width = 7'(aw); hblank = 12'(hb);
    field_len = 9'(fl); vblank = 10'(vb); act_lines = 10'(vl); lock_mode = lk;
    @(negedge clk);
    rst_n = 1'b1;
    m_pix = 0; m_line = 0; m_arm = 0;
    compare({tag, " R9 reset"});
    for (int i = 0; i < ncyc; i++) begin
      if (rate == 1) vref = 1'b1;
      else if (last_px) vref = (m_pix == 4 * ll - 1) && ($urandom % 3 == 0);
      else if (rate > 1) vref = ($urandom % rate) == 0;
      else vref = 1'b0;
      @(negedge clk);
      advance(vref);
      compare(tag);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog act=%0d cycles exp<=150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // Directed: plain free-running frame (R1 R2 R3 R4 R5 R6)
    run_cfg(6, 1, 4, 5, 2, 5, 1'b0, 0, 1'b0, 1500, "basic");
    // Directed: windows past line and field end, cut-off (R3 R6)
    run_cfg(5, 2, 10, 4, 5, 10, 1'b0, 0, 1'b0, 1500, "cutoff");
    // Directed: hblank zero, full-width active (R3)
    run_cfg(4, 1, 0, 3, 0, 6, 1'b0, 0, 1'b0, 800, "hb0");
    // Directed: free-running with dense vref, must be ignored (R8)
    run_cfg(5, 1, 3, 4, 1, 3, 1'b0, 3, 1'b0, 2000, "free_vref");
    // Directed: locked, vref held high, line stays 0 (R7)
    run_cfg(4, 1, 2, 2, 0, 2, 1'b1, 1, 1'b0, 800, "lock_hold");
    // Directed: locked with tiny field_len and no pulses, register ignored (R7)
    run_cfg(4, 1, 2, 1, 3, 6, 1'b1, 0, 1'b0, 1500, "lock_nofield");
    // Directed: locked, pulses only on last pixel of line (R7)
    run_cfg(5, 1, 1, 2, 1, 4, 1'b1, 0, 1'b1, 3000, "lock_lastpx");
    // Random configurations
    for (int k = 0; k < 8; k++) begin
      int ll = 3 + int'($urandom % 18);
      int aw = int'($urandom % 5);
      int hb = int'($urandom % 80);
      int fl = 1 + int'($urandom % 10);
      int vb = int'($urandom % 12);
      int vl = int'($urandom % 16);
      bit lk = 1'($urandom % 2);
      int rt = lk ? 50 + int'($urandom % 300) : int'($urandom % 20);
      run_cfg(ll, aw, hb, fl, vb, vl, lk, rt, 1'b0, 2500, "random");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule